// File: doc/BRIEF.md
# Loop Replay Buffer with Front-End Sleep

This block sits on the micro-op path between the decoder and the scheduler. In normal operation it forwards each decoded micro-op straight through on lane 0. When the branch predictor flags a tight loop and supplies the target PC of its backward branch, the block records the micro-ops of one loop iteration as they pass. Recording begins at the first micro-op whose PC equals the target. It ends when a micro-op with the target PC shows up again.

After a complete iteration has been recorded, the block stops taking decoder input and asserts a sleep request to the fetch and decode stages. It then plays the stored body back on all output lanes every cycle. Playback wraps from the last stored entry to the first. It continues until a loop-exit or redirect event arrives. On that event the stored loop is discarded and the sleep request drops. The outputs stay silent until the front end reports that it is ready again. A loop body that is larger than the storage abandons recording, and the front end is never put to sleep for it.

Top module: `loop_replay_buf`

## Requirements
- R1: While reset is held, and when idle with no input, no output lane is valid and `fe_sleep` is 0.
- R2: When idle, each valid input micro-op appears on lane 0 (`out_uop[UOP_W-1:0]`) in the same cycle. Lanes 1 and up are invalid.
- R3: A pulse on `loop_hint` arms recording for `loop_target`. Micro-ops before the first one whose PC equals the target are not recorded. Recording starts with that micro-op. Every recorded micro-op is still forwarded on lane 0 in its own cycle.
- R4: The first valid micro-op after the start of recording whose PC equals the target closes the loop. It is not forwarded. `fe_sleep` is 1 from the next cycle.
- R5: While replaying, all `LANES` lanes are valid each cycle and input micro-ops are ignored. In replay cycle n (from 0), lane k (lane k at bits `k*UOP_W`) carries stored entry (LANES*n+k) mod L, where L is the loop length and entry 0 is the target micro-op. L may be smaller than `LANES`.
- R6: A loop of exactly DEPTH micro-ops replays. When a DEPTH+1-th micro-op would have to be recorded, recording is abandoned and that micro-op is forwarded. A later target-PC micro-op then starts no replay, and `fe_sleep` stays 0.
- R7: In the cycle `loop_exit` is high during replay, no lane is valid. From the next cycle `fe_sleep` is 0 and no lane is valid until a cycle in which `fe_ready` is high. Pass-through resumes in the cycle after that.
- R8: `loop_exit` during recording abandons the loop. The micro-op of that cycle is still forwarded, and a later target-PC micro-op starts no replay.
- R9: `loop_hint` is ignored while recording or replaying. Recording keeps its first target, and the replayed stream is unchanged.
- R10: After an exit, the old loop is fully cleared, and a new hint records a new loop from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoder micro-op valid |
| in_pc | input | PC_W | PC of the incoming micro-op |
| in_uop | input | UOP_W | Incoming micro-op payload |
| loop_hint | input | 1 | Predictor flags a tight loop (pulse) |
| loop_target | input | PC_W | Target PC of the loop's backward branch |
| loop_exit | input | 1 | Loop exit or redirect event |
| fe_ready | input | 1 | Front end awake again after sleep |
| out_valid | output | LANES | Per-lane valid toward the scheduler |
| out_uop | output | LANES*UOP_W | Per-lane micro-op payload, lane k at bits k*UOP_W |
| fe_sleep | output | 1 | Request to shut down fetch and decode |

## Verification
The bench builds the block with DEPTH=8 and LANES=4, keeping 16-bit PCs and payloads. The small depth allows a sweep over every loop length from 1 to the full capacity. That sweep covers lengths below the lane count, where one replay cycle repeats entries, as well as the exact-capacity and one-past-capacity boundaries. Each length is replayed for several cycles, so that every wrap phase of the lane index chain is compared against (4n+k) mod L.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_REPLAY  = 2'd2,
        ST_WAKE    = 2'd3
    } lrb_state_e;
endpackage

// File: rtl/lrb_store.sv
module lrb_store #(
    parameter int DEPTH = 48,
    parameter int UOP_W = 16,
    parameter int LANES = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [AW-1:0]                wr_addr,
    input  logic [UOP_W-1:0]             wr_data,
    input  logic [LANES-1:0][AW-1:0]     rd_addr,
    output logic [LANES-1:0][UOP_W-1:0]  rd_data
);
    logic [UOP_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_rd
        assign rd_data[k] = mem[rd_addr[k]];
    end
endmodule

// File: rtl/lrb_index.sv
module lrb_index #(
    parameter int DEPTH = 48,
    parameter int LANES = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      active,
    input  logic [CNT_W-1:0]          base,
    input  logic [CNT_W-1:0]          len,
    output logic [LANES-1:0][AW-1:0]  idx,
    output logic [CNT_W-1:0]          next
);
    logic [LANES:0][CNT_W-1:0] chain;

    assign chain[0] = base;

    for (genvar k = 0; k < LANES; k++) begin : g_chain
        logic [CNT_W-1:0] inc;
        assign inc          = chain[k] + CNT_W'(1);
        assign chain[k+1]   = (inc == len) ? '0 : inc;
        assign idx[k]       = chain[k][AW-1:0];

        // R5: every lane reads an entry inside the recorded loop
        assert_idx_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
            active |-> (chain[k] < len));
    end

    assign next = chain[LANES];
endmodule

// File: rtl/lrb_ctrl.sv
module lrb_ctrl
    import lrb_pkg::*;
#(
    parameter int DEPTH = 48,
    parameter int PC_W  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PC_W-1:0]   in_pc,
    input  logic              loop_hint,
    input  logic [PC_W-1:0]   loop_target,
    input  logic              loop_exit,
    input  logic              fe_ready,
    input  logic [CNT_W-1:0]  next_rd,
    output lrb_state_e        state_o,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic              pass_en,
    output logic [CNT_W-1:0]  rd_base,
    output logic [CNT_W-1:0]  loop_len
);
    typedef struct packed {
        lrb_state_e       state;
        logic [PC_W-1:0]  tgt;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rd;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  hit;

    assign hit = (in_pc == ctl_q.tgt);

    always_comb begin
        ctl_d   = ctl_q;
        wr_en   = 1'b0;
        pass_en = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                pass_en = in_valid;
                if (loop_hint) begin
                    ctl_d.state = ST_CAPTURE;
                    ctl_d.tgt   = loop_target;
                    ctl_d.cnt   = '0;
                end
            end
            ST_CAPTURE: begin
                if (loop_exit) begin
                    pass_en     = in_valid;
                    ctl_d.state = ST_IDLE;
                    ctl_d.cnt   = '0;
                end else if (in_valid) begin
                    if (hit && ctl_q.cnt != '0) begin
                        ctl_d.state = ST_REPLAY;
                        ctl_d.rd    = '0;
                    end else if (!hit && ctl_q.cnt == '0) begin
                        pass_en = 1'b1;
                    end else if (ctl_q.cnt == CNT_W'(DEPTH)) begin
                        pass_en     = 1'b1;
                        ctl_d.state = ST_IDLE;
                        ctl_d.cnt   = '0;
                    end else begin
                        pass_en   = 1'b1;
                        wr_en     = 1'b1;
                        ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                    end
                end
            end
            ST_REPLAY: begin
                if (loop_exit) begin
                    ctl_d.state = ST_WAKE;
                    ctl_d.cnt   = '0;
                    ctl_d.rd    = '0;
                end else begin
                    ctl_d.rd = next_rd;
                end
            end
            ST_WAKE: begin
                if (fe_ready) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, tgt: '0, cnt: '0, rd: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state_o  = ctl_q.state;
    assign wr_addr  = ctl_q.cnt[AW-1:0];
    assign rd_base  = ctl_q.rd;
    assign loop_len = ctl_q.cnt;

    // R6: the recorded length never passes the storage depth
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.cnt <= CNT_W'(DEPTH));

    // R5: loop length is frozen for the whole replay
    assert_len_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_REPLAY && $past(ctl_q.state) == ST_REPLAY) |-> $stable(ctl_q.cnt));

    // R10: leaving replay empties the stored loop
    assert_exit_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_REPLAY && loop_exit) |=> (ctl_q.cnt == '0));
endmodule

// File: rtl/loop_replay_buf.sv
module loop_replay_buf
    import lrb_pkg::*;
#(
    parameter int DEPTH = 48,
    parameter int UOP_W = 16,
    parameter int PC_W  = 16,
    parameter int LANES = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [PC_W-1:0]         in_pc,
    input  logic [UOP_W-1:0]        in_uop,
    input  logic                    loop_hint,
    input  logic [PC_W-1:0]         loop_target,
    input  logic                    loop_exit,
    input  logic                    fe_ready,
    output logic [LANES-1:0]        out_valid,
    output logic [LANES*UOP_W-1:0]  out_uop,
    output logic                    fe_sleep
);
    lrb_state_e                 state;
    logic                       wr_en;
    logic [AW-1:0]              wr_addr;
    logic                       pass_en;
    logic [CNT_W-1:0]           rd_base;
    logic [CNT_W-1:0]           loop_len;
    logic [CNT_W-1:0]           next_rd;
    logic [LANES-1:0][AW-1:0]   rd_addr;
    logic [LANES-1:0][UOP_W-1:0] rd_data;
    logic                       replay_on;

    lrb_ctrl #(.DEPTH(DEPTH), .PC_W(PC_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_pc       (in_pc),
        .loop_hint   (loop_hint),
        .loop_target (loop_target),
        .loop_exit   (loop_exit),
        .fe_ready    (fe_ready),
        .next_rd     (next_rd),
        .state_o     (state),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .pass_en     (pass_en),
        .rd_base     (rd_base),
        .loop_len    (loop_len)
    );

    lrb_index #(.DEPTH(DEPTH), .LANES(LANES)) u_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state == ST_REPLAY),
        .base   (rd_base),
        .len    (loop_len),
        .idx    (rd_addr),
        .next   (next_rd)
    );

    lrb_store #(.DEPTH(DEPTH), .UOP_W(UOP_W), .LANES(LANES)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (in_uop),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign replay_on = (state == ST_REPLAY) && !loop_exit;
    assign fe_sleep  = (state == ST_REPLAY);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (k == 0) begin : g_first
            assign out_valid[k] = replay_on | pass_en;
            assign out_uop[k*UOP_W +: UOP_W] = replay_on ? rd_data[k] :
                                               (pass_en ? in_uop : '0);
        end else begin : g_rest
            assign out_valid[k] = replay_on;
            assign out_uop[k*UOP_W +: UOP_W] = replay_on ? rd_data[k] : '0;
        end
    end

    // R4: sleep begins only right after a completed recording
    assert_sleep_from_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fe_sleep) |-> ($past(state) == ST_CAPTURE));

    // R5: a replay cycle without exit fills every lane
    assert_full_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_sleep && !loop_exit) |-> (&out_valid));

    // R7: an exit during replay wakes the front end on the next cycle
    assert_exit_wakes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_sleep && loop_exit) |=> !fe_sleep);

    // R7: the first cycle after sleep ends is silent
    assert_wake_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fe_sleep) |-> (out_valid == '0));
endmodule

// File: tb/test_loop_replay_buf.sv
module test_loop_replay_buf;
    localparam int DEPTH = 8;
    localparam int UOP_W = 16;
    localparam int PC_W  = 16;
    localparam int LANES = 4;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic [PC_W-1:0]         in_pc = '0;
    logic [UOP_W-1:0]        in_uop = '0;
    logic                    loop_hint = 1'b0;
    logic [PC_W-1:0]         loop_target = '0;
    logic                    loop_exit = 1'b0;
    logic                    fe_ready = 1'b0;
    logic [LANES-1:0]        out_valid;
    logic [LANES*UOP_W-1:0]  out_uop;
    logic                    fe_sleep;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    loop_replay_buf #(.DEPTH(DEPTH), .UOP_W(UOP_W), .PC_W(PC_W), .LANES(LANES)) i_loop_replay_buf (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc), .in_uop(in_uop),
        .loop_hint(loop_hint), .loop_target(loop_target), .loop_exit(loop_exit),
        .fe_ready(fe_ready), .out_valid(out_valid), .out_uop(out_uop), .fe_sleep(fe_sleep)
    );

    function automatic logic [15:0] f(input logic [15:0] pc);
        return pc * 16'd7 + 16'h3C5A;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic settle;
        #2;
    endtask

    task automatic feed(input logic [15:0] pc);
        in_valid = 1'b1;
        in_pc    = pc;
        in_uop   = f(pc);
    endtask

    task automatic expect_pass(input string req, input logic [15:0] pc);
        chk(req, {28'd0, out_valid}, 32'h1);
        chk(req, {16'd0, out_uop[15:0]}, {16'd0, f(pc)});
        chk(req, {31'd0, fe_sleep}, 32'd0);
    endtask

    task automatic arm(input logic [15:0] t);
        in_valid = 1'b0; loop_hint = 1'b1; loop_target = t;
        settle;
        tick;
        loop_hint = 1'b0;
    endtask

    // Sweep body: record, replay, exit, wake
    task automatic run_loop(input int len, input logic [15:0] t, input bit poke);
        arm(t);
        feed(t - 16'd1); settle; expect_pass("R3", t - 16'd1); tick;
        for (int i = 0; i < len; i++) begin
            feed(t + 16'(i)); settle; expect_pass("R3", t + 16'(i)); tick;
        end
        feed(t); settle;
        chk("R4", {28'd0, out_valid}, 32'h0);
        tick;
        in_pc = 16'hFFFF; in_uop = 16'hDEAD;
        for (int n = 0; n < 4; n++) begin
            loop_hint   = poke && (n == 1);
            loop_target = t + 16'd1;
            settle;
            chk("R4", {31'd0, fe_sleep}, 32'd1);
            chk("R5", {28'd0, out_valid}, 32'hF);
            for (int k = 0; k < LANES; k++) begin
                chk(poke ? "R9" : "R5", {16'd0, out_uop[k*UOP_W +: UOP_W]},
                    {16'd0, f(t + 16'((4 * n + k) % len))});
            end
            tick;
        end
        loop_hint = 1'b0;
        loop_exit = 1'b1; settle;
        chk("R7", {28'd0, out_valid}, 32'h0);
        chk("R7", {31'd0, fe_sleep}, 32'd1);
        tick;
        loop_exit = 1'b0;
        for (int w = 0; w < 2; w++) begin
            settle;
            chk("R7", {28'd0, out_valid}, 32'h0);
            chk("R7", {31'd0, fe_sleep}, 32'd0);
            tick;
        end
        fe_ready = 1'b1; settle;
        chk("R7", {28'd0, out_valid}, 32'h0);
        tick;
        fe_ready = 1'b0;
        feed(t); settle; expect_pass("R10", t); tick;
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        chk("R1", {28'd0, out_valid}, 32'h0);
        chk("R1", {31'd0, fe_sleep}, 32'd0);
        rst_n = 1'b1;
        tick;
        chk("R1", {28'd0, out_valid}, 32'h0);
        chk("R1", {31'd0, fe_sleep}, 32'd0);

        // R2: plain pass-through
        for (int i = 0; i < 6; i++) begin
            feed(16'h0040 + 16'(i * 3)); settle;
            expect_pass("R2", 16'h0040 + 16'(i * 3));
            tick;
        end
        in_valid = 1'b0;

        // R3 R4 R5 R7 R10: every length up to capacity (R6 exact fit at DEPTH)
        for (int len = 1; len <= DEPTH; len++) begin
            run_loop(len, 16'h0100 * 16'(len), len == 3);
        end

        // R6: one past capacity abandons the loop
        arm(16'h2000);
        for (int i = 0; i < DEPTH; i++) begin
            feed(16'h2000 + 16'(i)); settle; expect_pass("R6", 16'h2000 + 16'(i)); tick;
        end
        feed(16'h2000 + 16'(DEPTH)); settle; expect_pass("R6", 16'h2000 + 16'(DEPTH)); tick;
        feed(16'h2000); settle; expect_pass("R6", 16'h2000); tick;
        in_valid = 1'b0; settle;
        chk("R6", {31'd0, fe_sleep}, 32'd0);
        chk("R6", {28'd0, out_valid}, 32'h0);
        tick;

        // R8: exit while recording
        arm(16'h3000);
        feed(16'h3000); settle; expect_pass("R8", 16'h3000); tick;
        feed(16'h3001); settle; expect_pass("R8", 16'h3001); tick;
        loop_exit = 1'b1;
        feed(16'h3002); settle; expect_pass("R8", 16'h3002); tick;
        loop_exit = 1'b0;
        feed(16'h3000); settle; expect_pass("R8", 16'h3000); tick;
        in_valid = 1'b0; settle;
        chk("R8", {31'd0, fe_sleep}, 32'd0);
        tick;

        // R9: hint during recording keeps the first target
        arm(16'h4000);
        feed(16'h4000); settle; tick;
        loop_hint = 1'b1; loop_target = 16'h4032;
        feed(16'h4001); settle; expect_pass("R9", 16'h4001); tick;
        loop_hint = 1'b0;
        feed(16'h4002); settle; tick;
        feed(16'h4000); settle;
        chk("R9", {28'd0, out_valid}, 32'h0);
        tick;
        in_valid = 1'b0; settle;
        chk("R9", {31'd0, fe_sleep}, 32'd1);
        chk("R9", {16'd0, out_uop[0 +: 16]},  {16'd0, f(16'h4000)});
        chk("R9", {16'd0, out_uop[16 +: 16]}, {16'd0, f(16'h4001)});
        chk("R9", {16'd0, out_uop[32 +: 16]}, {16'd0, f(16'h4002)});
        chk("R9", {16'd0, out_uop[48 +: 16]}, {16'd0, f(16'h4000)});
        tick;
        loop_exit = 1'b1; settle; tick;
        loop_exit = 1'b0; fe_ready = 1'b1; settle; tick;
        fe_ready = 1'b0;
        feed(16'h0077); settle; expect_pass("R7", 16'h0077); tick;
        in_valid = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule